// File: doc/BRIEF.md
# Resolver signal fault monitor

This block supervises the digitized sine and cosine channels of a resolver interface and the error word of the angle-tracking loop. It drives two active-low fault flags. The signal-degradation flag `dos_n_o` goes low while the most recent sample of either channel is too large in magnitude. It also goes low, and stays low, once the sine and cosine amplitudes measured over one excitation period differ by more than a set margin. The tracking flag `lot_n_o` goes low when the loop error grows too large. It uses a hysteresis band, so it comes back high only after the error has dropped clearly below the trip level.

Every valid sample is checked for over-range, so a bad input shows on the flag one cycle after it arrives. The amplitude of each channel is the peak magnitude held across an excitation period. The period boundary is given by the `period_i` strobe. The four limits are registers written through a small configuration port, and each has a reset default that is a fixed fraction of full scale. A three-bit sticky status word records which fault classes have been seen. Software clears it together with the mismatch latch by pulsing `clr_i` after it reads the status.

Top module: `rsv_fault_mon`

## Requirements
- R1: After synchronous reset `dos_n_o` and `lot_n_o` are 1 and `status_o` is 0. The limits take their defaults: over-range 1792, mismatch 256, tracking 128, hysteresis 32 (for 12-bit words).
- R2: A sample with `smp_vld_i` high whose sine or cosine magnitude is strictly above the over-range limit drives `dos_n_o` low from the next cycle. A valid sample with both magnitudes at or below the limit releases that cause from the next cycle. The magnitude of the most negative code -2^(W-1) is 2^(W-1).
- R3: Each channel holds the peak magnitude of its valid samples since the last `period_i` pulse. On `period_i` that peak becomes the channel amplitude. A sample arriving in the same cycle as `period_i` is not part of the closing period; it starts the new peak.
- R4: When the two captured amplitudes differ by strictly more than the mismatch limit, `dos_n_o` goes low at the second clock edge after the `period_i` pulse. It then stays low whatever samples follow, until `clr_i` or reset.
- R5: An error word with `err_vld_i` high whose magnitude is strictly above the tracking limit drives `lot_n_o` low from the next cycle.
- R6: Once low, `lot_n_o` returns high only after a valid error word whose magnitude is strictly below the tracking limit minus the hysteresis margin. That release level is 0, so no release is possible, when the margin is at or above the limit. Without `err_vld_i` the flag does not change.
- R7: `status_o` bit 0 records an over-range sample, bit 1 a mismatch detection and bit 2 a tracking trip. Each bit stays set until `clr_i`. A set and a clear in the same cycle leave the bit set.
- R8: `clr_i` releases the mismatch latch. It does not affect the over-range cause or `lot_n_o`.
- R9: A write with `cfg_we_i` high stores `cfg_wdata_i` into the limit chosen by `cfg_sel_i`: 0 over-range, 1 mismatch, 2 tracking, 3 hysteresis. The new value is used from the next cycle.
- R10: Sample words presented with `smp_vld_i` low change neither the flags nor the held peaks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| smp_vld_i | input | 1 | Sine/cosine sample strobe |
| sin_i | input | SMP_W | Signed sine sample |
| cos_i | input | SMP_W | Signed cosine sample |
| period_i | input | 1 | Excitation period boundary pulse |
| err_vld_i | input | 1 | Tracking error strobe |
| err_i | input | ERR_W | Signed tracking loop error |
| cfg_we_i | input | 1 | Limit register write enable |
| cfg_sel_i | input | 2 | Limit register select |
| cfg_wdata_i | input | CFG_W | Limit write data |
| clr_i | input | 1 | Clears sticky status and mismatch latch |
| dos_n_o | output | 1 | Signal degradation flag, active low |
| lot_n_o | output | 1 | Loss of tracking flag, active low |
| status_o | output | 3 | Sticky fault record |

## Verification
The bench sweeps every sine code against an over-range limit and checks the flag exactly at the limit and at the most negative code. A comparison of the wrong sense, or a magnitude that wraps, would flag the wrong codes. Mismatch cases sit on and just past the margin, in both directions. One case places a sample in the same cycle as the period strobe, so a design that folded that sample into the closing period would latch a false mismatch. The tracking error is ramped up and down through the hysteresis band against an arithmetic model, which catches a flag that releases at the trip level or that fails to latch.

// File: rtl/rsv_fault_pkg.sv
package rsv_fault_pkg;

   typedef enum logic [1:0] {
      LIM_OVR  = 2'd0,
      LIM_MM   = 2'd1,
      LIM_TRK  = 2'd2,
      LIM_HYS  = 2'd3
   } lim_sel_e;

   localparam int ST_OVR  = 0;
   localparam int ST_MM   = 1;
   localparam int ST_LOT  = 2;
   localparam int ST_W    = 3;

   // reset defaults as fractions of the positive full scale
   localparam int OVR_CUT_DIV = 8;    // over-range = FS - FS/8
   localparam int MM_DIV      = 8;    // mismatch   = FS/8
   localparam int TRK_DIV     = 16;   // tracking   = FS/16
   localparam int HYS_DIV     = 64;   // hysteresis = FS/64

endpackage

// File: rtl/rsv_lim_regs.sv
module rsv_lim_regs
   import rsv_fault_pkg::*;
#(
   parameter int SMP_W = 12,
   parameter int ERR_W = 12,
   parameter int CFG_W = 12
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             we_i,
   input  logic [1:0]       sel_i,
   input  logic [CFG_W-1:0] wdata_i,
   output logic [SMP_W-1:0] ovr_lim_o,
   output logic [SMP_W-1:0] mm_lim_o,
   output logic [ERR_W-1:0] trk_lim_o,
   output logic [ERR_W-1:0] hys_lim_o
);

   localparam int SFS = 2 ** (SMP_W - 1);
   localparam int EFS = 2 ** (ERR_W - 1);
   localparam logic [SMP_W-1:0] OVR_DEF = SMP_W'(SFS - SFS / OVR_CUT_DIV);
   localparam logic [SMP_W-1:0] MM_DEF  = SMP_W'(SFS / MM_DIV);
   localparam logic [ERR_W-1:0] TRK_DEF = ERR_W'(EFS / TRK_DIV);
   localparam logic [ERR_W-1:0] HYS_DEF = ERR_W'(EFS / HYS_DIV);

   lim_sel_e sel;
   assign sel = lim_sel_e'(sel_i);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         ovr_lim_o <= OVR_DEF;
         mm_lim_o  <= MM_DEF;
         trk_lim_o <= TRK_DEF;
         hys_lim_o <= HYS_DEF;
      end else if (we_i) begin
         unique case (sel)
            LIM_OVR: ovr_lim_o <= wdata_i[SMP_W-1:0];
            LIM_MM:  mm_lim_o  <= wdata_i[SMP_W-1:0];
            LIM_TRK: trk_lim_o <= wdata_i[ERR_W-1:0];
            LIM_HYS: hys_lim_o <= wdata_i[ERR_W-1:0];
            default: ;
         endcase
      end
   end

   p_cfg_ovr_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      (we_i && sel_i == 2'd0) |=> (ovr_lim_o == $past(wdata_i[SMP_W-1:0])));
   p_cfg_trk_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      (we_i && sel_i == 2'd2) |=> (trk_lim_o == $past(wdata_i[ERR_W-1:0])));
   p_cfg_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      !we_i |=> ($stable(ovr_lim_o) && $stable(mm_lim_o)
                 && $stable(trk_lim_o) && $stable(hys_lim_o)));

endmodule

// File: rtl/rsv_peak_hold.sv
module rsv_peak_hold #(
   parameter int SMP_W = 12
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             vld_i,
   input  logic [SMP_W-1:0] smp_i,
   input  logic             period_i,
   output logic [SMP_W-1:0] mag_o,
   output logic [SMP_W-1:0] amp_o,
   output logic             amp_vld_o
);

   logic [SMP_W-1:0] peak_q;

   // two's complement magnitude, unsigned, so -FS maps to FS without wrap
   assign mag_o = smp_i[SMP_W-1] ? (~smp_i + 1'b1) : smp_i;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         peak_q    <= '0;
         amp_o     <= '0;
         amp_vld_o <= 1'b0;
      end else begin
         amp_vld_o <= period_i;
         if (period_i) begin
            amp_o  <= peak_q;
            peak_q <= vld_i ? mag_o : '0;
         end else if (vld_i && (mag_o > peak_q)) begin
            peak_q <= mag_o;
         end
      end
   end

   p_peak_mono_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      !period_i |=> (peak_q >= $past(peak_q)));
   p_peak_cap_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      period_i |=> (amp_o == $past(peak_q)));
   p_peak_idle_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      (!vld_i && !period_i) |=> $stable(peak_q));

endmodule

// File: rtl/rsv_dos_eval.sv
module rsv_dos_eval #(
   parameter int SMP_W = 12
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             smp_vld_i,
   input  logic [SMP_W-1:0] mag_s_i,
   input  logic [SMP_W-1:0] mag_c_i,
   input  logic             amp_vld_i,
   input  logic [SMP_W-1:0] amp_s_i,
   input  logic [SMP_W-1:0] amp_c_i,
   input  logic [SMP_W-1:0] ovr_lim_i,
   input  logic [SMP_W-1:0] mm_lim_i,
   input  logic             clr_i,
   output logic             ovr_hit_o,
   output logic             mm_hit_o,
   output logic             dos_n_o
);

   logic             ovr_q;
   logic             mm_q;
   logic [SMP_W-1:0] amp_gap;

   assign ovr_hit_o = smp_vld_i && ((mag_s_i > ovr_lim_i) || (mag_c_i > ovr_lim_i));
   assign amp_gap   = (amp_s_i >= amp_c_i) ? (amp_s_i - amp_c_i) : (amp_c_i - amp_s_i);
   assign mm_hit_o  = amp_vld_i && (amp_gap > mm_lim_i);

   // over-range cause follows the latest valid sample
   always_ff @(posedge clk_i) begin
      if (rst_i)          ovr_q <= 1'b0;
      else if (smp_vld_i) ovr_q <= ovr_hit_o;
   end

   // mismatch cause is latched; detection wins over a same-cycle clear
   always_ff @(posedge clk_i) begin
      if (rst_i)         mm_q <= 1'b0;
      else if (mm_hit_o) mm_q <= 1'b1;
      else if (clr_i)    mm_q <= 1'b0;
   end

   assign dos_n_o = ~(ovr_q | mm_q);

   p_ovr_set_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (smp_vld_i && (mag_s_i > ovr_lim_i || mag_c_i > ovr_lim_i)) |=> !dos_n_o);
   p_ovr_rel_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (smp_vld_i && mag_s_i <= ovr_lim_i && mag_c_i <= ovr_lim_i) |=> (dos_n_o || mm_q));
   p_mm_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      (mm_q && !clr_i) |=> !dos_n_o);
   p_novld_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      (!smp_vld_i && !amp_vld_i && !clr_i) |=> $stable(dos_n_o));

endmodule

// File: rtl/rsv_lot_eval.sv
module rsv_lot_eval #(
   parameter int ERR_W = 12
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             err_vld_i,
   input  logic [ERR_W-1:0] err_i,
   input  logic [ERR_W-1:0] trk_lim_i,
   input  logic [ERR_W-1:0] hys_lim_i,
   output logic             trip_o,
   output logic             lot_n_o
);

   logic [ERR_W-1:0] mag;
   logic [ERR_W-1:0] rel_lvl;
   logic             release_ok;
   logic             lot_q;

   assign mag        = err_i[ERR_W-1] ? (~err_i + 1'b1) : err_i;
   assign rel_lvl    = (trk_lim_i > hys_lim_i) ? (trk_lim_i - hys_lim_i) : '0;
   assign trip_o     = err_vld_i && (mag > trk_lim_i);
   assign release_ok = err_vld_i && (mag < rel_lvl);

   always_ff @(posedge clk_i) begin
      if (rst_i)           lot_q <= 1'b0;
      else if (trip_o)     lot_q <= 1'b1;
      else if (release_ok) lot_q <= 1'b0;
   end

   assign lot_n_o = ~lot_q;

   p_lot_trip_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      (err_vld_i && mag > trk_lim_i) |=> !lot_n_o);
   p_lot_band_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      (!lot_n_o && err_vld_i && ({1'b0, mag} + {1'b0, hys_lim_i} >= {1'b0, trk_lim_i}))
      |=> !lot_n_o);
   p_lot_idle_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      !err_vld_i |=> $stable(lot_n_o));

endmodule

// File: rtl/rsv_fault_mon.sv
module rsv_fault_mon
   import rsv_fault_pkg::*;
#(
   parameter int SMP_W = 12,
   parameter int ERR_W = 12,
   parameter int CFG_W = (SMP_W > ERR_W) ? SMP_W : ERR_W
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             smp_vld_i,
   input  logic [SMP_W-1:0] sin_i,
   input  logic [SMP_W-1:0] cos_i,
   input  logic             period_i,
   input  logic             err_vld_i,
   input  logic [ERR_W-1:0] err_i,
   input  logic             cfg_we_i,
   input  logic [1:0]       cfg_sel_i,
   input  logic [CFG_W-1:0] cfg_wdata_i,
   input  logic             clr_i,
   output logic             dos_n_o,
   output logic             lot_n_o,
   output logic [2:0]       status_o
);

   localparam int NCH = 2;

   if (SMP_W < 4 || SMP_W > 32) begin : g_bad_smp_w
      $error("rsv_fault_mon: SMP_W out of range");
   end
   if (ERR_W < 4 || ERR_W > 32) begin : g_bad_err_w
      $error("rsv_fault_mon: ERR_W out of range");
   end
   if (CFG_W < SMP_W || CFG_W < ERR_W) begin : g_bad_cfg_w
      $error("rsv_fault_mon: CFG_W narrower than a limit");
   end

   logic [SMP_W-1:0] ovr_lim, mm_lim;
   logic [ERR_W-1:0] trk_lim, hys_lim;

   rsv_lim_regs #(.SMP_W(SMP_W), .ERR_W(ERR_W), .CFG_W(CFG_W)) u_lim (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .we_i      (cfg_we_i),
      .sel_i     (cfg_sel_i),
      .wdata_i   (cfg_wdata_i),
      .ovr_lim_o (ovr_lim),
      .mm_lim_o  (mm_lim),
      .trk_lim_o (trk_lim),
      .hys_lim_o (hys_lim)
   );

   logic [SMP_W-1:0] ch_smp [NCH];
   logic [SMP_W-1:0] ch_mag [NCH];
   logic [SMP_W-1:0] ch_amp [NCH];
   logic [NCH-1:0]   ch_amp_vld;

   assign ch_smp[0] = sin_i;
   assign ch_smp[1] = cos_i;

   for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
      rsv_peak_hold #(.SMP_W(SMP_W)) u_peak (
         .clk_i     (clk_i),
         .rst_i     (rst_i),
         .vld_i     (smp_vld_i),
         .smp_i     (ch_smp[gi]),
         .period_i  (period_i),
         .mag_o     (ch_mag[gi]),
         .amp_o     (ch_amp[gi]),
         .amp_vld_o (ch_amp_vld[gi])
      );
   end

   logic ovr_hit, mm_hit, trk_trip;

   rsv_dos_eval #(.SMP_W(SMP_W)) u_dos (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .smp_vld_i (smp_vld_i),
      .mag_s_i   (ch_mag[0]),
      .mag_c_i   (ch_mag[1]),
      .amp_vld_i (&ch_amp_vld),
      .amp_s_i   (ch_amp[0]),
      .amp_c_i   (ch_amp[1]),
      .ovr_lim_i (ovr_lim),
      .mm_lim_i  (mm_lim),
      .clr_i     (clr_i),
      .ovr_hit_o (ovr_hit),
      .mm_hit_o  (mm_hit),
      .dos_n_o   (dos_n_o)
   );

   rsv_lot_eval #(.ERR_W(ERR_W)) u_lot (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .err_vld_i (err_vld_i),
      .err_i     (err_i),
      .trk_lim_i (trk_lim),
      .hys_lim_i (hys_lim),
      .trip_o    (trk_trip),
      .lot_n_o   (lot_n_o)
   );

   logic [ST_W-1:0] st_set;
   logic [ST_W-1:0] st_q;

   assign st_set[ST_OVR] = ovr_hit;
   assign st_set[ST_MM]  = mm_hit;
   assign st_set[ST_LOT] = trk_trip;

   for (genvar gb = 0; gb < ST_W; gb++) begin : g_st
      always_ff @(posedge clk_i) begin
         if (rst_i)            st_q[gb] <= 1'b0;
         else if (st_set[gb])  st_q[gb] <= 1'b1;
         else if (clr_i)       st_q[gb] <= 1'b0;
      end
   end

   assign status_o = st_q;

   p_status_sticky_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      !clr_i |=> ((status_o & $past(status_o)) == $past(status_o)));
   p_status_lot_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(lot_n_o) |-> status_o[2]);
   p_clr_lot_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      (clr_i && !err_vld_i) |=> $stable(lot_n_o));

endmodule

// File: tb/rsv_fault_mon_tb.sv
module rsv_fault_mon_tb;

   localparam int W = 12;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         smp_vld = 1'b0;
   logic [W-1:0] sin_w = '0;
   logic [W-1:0] cos_w = '0;
   logic         period = 1'b0;
   logic         err_vld = 1'b0;
   logic [W-1:0] err_w = '0;
   logic         cfg_we = 1'b0;
   logic [1:0]   cfg_sel = '0;
   logic [W-1:0] cfg_wdata = '0;
   logic         clr = 1'b0;
   logic         dos_n, lot_n;
   logic [2:0]   status;

   int n_run  = 0;
   int n_fail = 0;
   int trk_m  = 128;
   int hys_m  = 32;
   bit lot_m  = 1'b0;

   always #4 clk = ~clk;

   rsv_fault_mon #(.SMP_W(W), .ERR_W(W)) u_dut (
      .clk_i(clk), .rst_i(rst), .smp_vld_i(smp_vld), .sin_i(sin_w), .cos_i(cos_w),
      .period_i(period), .err_vld_i(err_vld), .err_i(err_w), .cfg_we_i(cfg_we),
      .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata), .clr_i(clr),
      .dos_n_o(dos_n), .lot_n_o(lot_n), .status_o(status)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic settle();
      @(posedge clk); #1;
      smp_vld = 0; period = 0; err_vld = 0; cfg_we = 0; clr = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin @(negedge clk); settle(); end
   endtask

   task automatic smp(input int s, input int c);
      @(negedge clk); smp_vld = 1; sin_w = W'(s); cos_w = W'(c); settle();
   endtask

   task automatic per(input bit v, input int s, input int c);
      @(negedge clk); period = 1; smp_vld = v; sin_w = W'(s); cos_w = W'(c); settle();
   endtask

   task automatic cfg(input int sel, input int val);
      @(negedge clk); cfg_we = 1; cfg_sel = 2'(sel); cfg_wdata = W'(val); settle();
   endtask

   task automatic do_clr();
      @(negedge clk); clr = 1; settle();
   endtask

   function automatic int iabs(input int v);
      return (v < 0) ? -v : v;
   endfunction

   task automatic err(input int e);
      int m, rel;
      @(negedge clk); err_vld = 1; err_w = W'(e); settle();
      m   = iabs(e);
      rel = (trk_m > hys_m) ? trk_m - hys_m : 0;
      if (m > trk_m)    lot_m = 1'b1;
      else if (m < rel) lot_m = 1'b0;
      chk(lot_n == !lot_m, (m > trk_m) ? "R5 trip" : "R6 hysteresis", lot_n, !lot_m);
   endtask

   task automatic mm_case(input int a, input int b, input bit latch);
      smp(a, b);
      smp(a / 2, -b / 2);
      per(0, 0, 0);
      chk(dos_n == 1'b1, "R4 no flag at capture edge", dos_n, 1);
      idle(1);
      chk(dos_n == !latch, "R4 mismatch detect", dos_n, !latch);
      chk(status[1] == latch, "R7 mismatch status", status[1], latch);
      if (latch) begin
         smp(100, 100);
         chk(dos_n == 1'b0, "R4 latch holds", dos_n, 0);
         do_clr();
         chk(dos_n == 1'b1, "R8 clear releases latch", dos_n, 1);
         chk(status[1] == 1'b0, "R7 clear status", status[1], 0);
      end
   endtask

   initial begin
      #(200000 * 8);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      idle(3);
      rst = 0;
      idle(1);
      // R1 reset state
      chk(dos_n == 1'b1, "R1 dos after reset", dos_n, 1);
      chk(lot_n == 1'b1, "R1 lot after reset", lot_n, 1);
      chk(status == 3'b000, "R1 status after reset", status, 0);

      // R1 default limits at the ports
      smp(1792, 0);
      chk(dos_n == 1'b1, "R1 default over-range at limit", dos_n, 1);
      smp(0, -1793);
      chk(dos_n == 1'b0, "R1 default over-range past limit", dos_n, 0);
      err(128); err(129); err(96); err(95);

      // R10 samples without strobe
      smp(0, 0);
      @(negedge clk); sin_w = W'(2047); cos_w = W'(-2048); settle();
      chk(dos_n == 1'b1, "R10 unstrobed sample ignored", dos_n, 1);

      // R9 + R2 exhaustive sine sweep against a written limit
      cfg(0, 1000);
      for (int v = -2048; v < 2048; v++) begin
         smp(v, 0);
         chk(dos_n == !(iabs(v) > 1000), "R2 sine over-range", dos_n, !(iabs(v) > 1000));
      end
      for (int v = -1100; v <= -900; v++) begin
         smp(0, v);
         chk(dos_n == !(iabs(v) > 1000), "R2 cosine over-range", dos_n, !(iabs(v) > 1000));
      end
      chk(status[0] == 1'b1, "R7 over-range status", status[0], 1);

      // sync period and clear stale mismatch from the sweep
      per(0, 0, 0);
      idle(1);
      do_clr();
      chk(status == 3'b000, "R7 clear all", status, 0);
      chk(dos_n == 1'b1, "R8 dos after clear", dos_n, 1);

      // R7 set and clear in the same cycle
      @(negedge clk); smp_vld = 1; sin_w = W'(1500); cos_w = '0; clr = 1; settle();
      chk(status[0] == 1'b1, "R7 set beats clear", status[0], 1);
      smp(0, 0);
      do_clr();
      chk(dos_n == 1'b1, "R2 release after good sample", dos_n, 1);

      // R4 mismatch edges, both directions
      per(0, 0, 0);
      idle(1);
      do_clr();
      mm_case(600, 600, 0);
      mm_case(600, 344, 0);
      mm_case(600, 343, 1);
      mm_case(-300, 700, 1);
      mm_case(500, -500, 0);

      // R9 mismatch limit write
      cfg(1, 50);
      mm_case(600, 549, 1);
      cfg(1, 256);

      // R3 same-cycle sample opens the next period
      smp(500, 500);
      per(1, 1000, 100);
      idle(1);
      chk(dos_n == 1'b1, "R3 same-cycle sample not in closing period", dos_n, 1);
      per(0, 0, 0);
      idle(1);
      chk(dos_n == 1'b0, "R3 same-cycle sample starts new peak", dos_n, 0);

      // R8 clear leaves over-range cause alone
      smp(1200, 0);
      do_clr();
      chk(dos_n == 1'b0, "R8 over-range survives clear", dos_n, 0);
      smp(0, 0);
      chk(dos_n == 1'b1, "R2 over-range released", dos_n, 1);

      // R5/R6 tracking ramp through hysteresis
      cfg(2, 100); trk_m = 100;
      cfg(3, 20);  hys_m = 20;
      err(0);
      for (int e = 0; e <= 150; e++) err(e);
      do_clr();
      chk(lot_n == 1'b0, "R8 clear leaves lot", lot_n, 0);
      for (int e = 150; e >= -150; e--) err(e);
      for (int e = -150; e <= 0; e++) err(e);
      chk(status[2] == 1'b1, "R7 lot status", status[2], 1);

      // R6 no strobe, no change
      err(130);
      @(negedge clk); err_w = W'(0); settle();
      chk(lot_n == 1'b0, "R6 unstrobed error ignored", lot_n, 0);

      // R6 margin at or above limit: no release
      cfg(3, 150); hys_m = 150;
      err(0); err(-1); err(5);
      cfg(3, 100); hys_m = 100;
      err(0);

      // R1 reset mid-run
      @(negedge clk); rst = 1; settle();
      @(negedge clk); rst = 0;
      lot_m = 0; trk_m = 128; hys_m = 32;
      #1;
      chk(lot_n == 1'b1, "R1 lot after second reset", lot_n, 1);
      chk(status == 3'b000, "R1 status after second reset", status, 0);
      smp(-1793, 0);
      chk(dos_n == 1'b0, "R1 over-range default restored", dos_n, 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule